// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block is the software-visible configuration front end of an AT-class memory controller. It occupies four consecutive I/O byte addresses on an 8/16-bit bus. Through them, software reaches two register groups. The first is a table of 64 page-mapping entries, each 12 bits wide, selected through a mapping index. The second is a set of seven byte-wide configuration registers, selected through a configuration index. The block stores all of these registers and presents their contents continuously to the memory decoders. It does not translate any addresses itself.

A mapping index with its top bit set advances by one after every access to the mapping data port, so a whole run of entries can be loaded or dumped with back-to-back accesses. Several configuration registers are not plain storage. They combine writable bits with values fixed by board straps (memory configuration and large-memory detect) and with values fixed by build parameters (chip revision, presence of the configuration index, presence of the sleep feature). A one-cycle change pulse after every write tells the decoders to reload.

Top module: `chipset_cfg_port`

## Requirements
- R1: Port offsets are decoded by `bus_addr`: 0 is mapping data, 1 is the configuration index, 2 is the mapping index, 3 is configuration data. Entry selection uses mapping index bits [5:0] and register selection uses configuration index bits [2:0]. Both index registers read back all 8 bits.
- R2: After any read or write of offset 0, the mapping index increments by one (modulo 256) if its bit 7 was set, and is left unchanged otherwise.
- R3: A byte write to offset 0 stores the data byte in entry bits [7:0] and sets entry bits [11:8] to ones. A word write stores `bus_wdata[11:0]`.
- R4: A word read of offset 0 returns the entry with bits [15:12] set. Bits [11:10] are also set when configuration register 4 bit 7 is clear. A byte read returns entry bits [7:0] in `bus_rdata[7:0]`.
- R5: Register 0 reads back as {strap_memcfg, five written bits}. Register 1 reads back as written with bit 6 replaced by `strap_cr1_bit`. Registers 2 and 3 hold all eight bits.
- R6: Register 4 bits [3:0] are writable, and bits [7:4] always read as the REVISION parameter.
- R7: Register 5 keeps all 8 written bits when HAS_SLEEP is 1, and only bits [3:0] (upper bits read 0) when it is 0.
- R8: When REVISION is 8, register 6 bits [7:1] are writable and bit 0 reads as `strap_big_mem`. On any other revision, register 6 reads 0x00.
- R9: After reset, register 0's writable bits are 0x04, registers 1 to 6 have their writable bits at zero, both indices are zero, and every mapping entry is zero.
- R10: Reads of absent locations return all ones on `bus_rdata`: configuration register 7, any word read of offsets 1 to 3, and offset 1 when HAS_CFG_INDEX is 0. Word writes to offsets 1 to 3, and configuration index writes when HAS_CFG_INDEX is 0, change nothing.
- R11: `cfg_changed` is high for exactly the one cycle after each clock edge that takes a write, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access to this block in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | input | 2 | Port offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current offset (combinational) |
| strap_memcfg | input | 3 | Strapped upper bits of register 0 |
| strap_cr1_bit | input | 1 | Strapped bit 6 of register 1 |
| strap_big_mem | input | 1 | Memory above 8 MB detect, register 6 bit 0 |
| cfg_regs | output | 56 | Read views of registers 0..6, register n in bits [8n+7:8n] |
| map_regs | output | NUM_MAP*MAP_W | Mapping entries, entry n in bits [12n+11:12n] |
| cfg_changed | output | 1 | One-cycle pulse after any write |

## Verification
The bench goes after the mapping index at its wrap points. Index 0xBF must step to 0xC0 and reach entry 0, and 0xFF must wrap to 0x00 and then stay put. A design that masks the increment to six bits, or keeps incrementing after the wrap, writes the wrong entry. It loads entries with byte writes and with word writes and reads them back as words under both settings of register 4 bit 7. This catches a missing forced nibble or the wrong OR mask. Each strapped, revision-gated and sleep-gated field is written with all ones and with all zeros, so a write that leaks into a strapped bit shows up at once. Writes that must be ignored are followed by a readback of the register they could have disturbed.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam logic [1:0] OFS_MAP_DATA = 2'd0;
  localparam logic [1:0] OFS_CFG_IDX  = 2'd1;
  localparam logic [1:0] OFS_MAP_IDX  = 2'd2;
  localparam logic [1:0] OFS_CFG_DATA = 2'd3;
  localparam int IDX_W       = 8;
  localparam int AUTOINC_BIT = 7;
  localparam int NUM_CFG     = 7;
  localparam int CFG_SEL_W   = 3;
  localparam logic [15:0] ALL_ONES = 16'hFFFF;
endpackage

// File: rtl/ccp_map_file.sv
module ccp_map_file
  import ccp_pkg::*;
#(
  parameter int NUM_MAP = 64,
  parameter int MAP_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     idx_we,
  input  logic                     data_acc,
  input  logic                     data_we,
  input  logic                     data_word,
  input  logic [15:0]              wdata,
  output logic [IDX_W-1:0]         idx_q,
  output logic [MAP_W-1:0]         sel_entry,
  output logic [NUM_MAP*MAP_W-1:0] map_flat
);
  localparam int SEL_W = $clog2(NUM_MAP);
  localparam int HI_W  = MAP_W - 8;

  logic [IDX_W-1:0]         idx_d;
  logic [NUM_MAP*MAP_W-1:0] ent_q;
  logic [MAP_W-1:0]         wr_val;
  logic [SEL_W-1:0]         sel;

  assign sel = idx_q[SEL_W-1:0];

  // index next state: load, auto-advance, or hold
  always_comb begin
    idx_d = idx_q;
    if (idx_we)
      idx_d = wdata[IDX_W-1:0];
    else if (data_acc && idx_q[AUTOINC_BIT])
      idx_d = idx_q + 8'd1;
  end

  // byte writes force the upper entry bits
  always_comb begin
    if (data_word)
      wr_val = wdata[MAP_W-1:0];
    else
      wr_val = {{HI_W{1'b1}}, wdata[7:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else
      idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ent_q <= '0;
    else if (data_we)
      ent_q[sel*MAP_W +: MAP_W] <= wr_val;
  end

  assign sel_entry = ent_q[sel*MAP_W +: MAP_W];
  assign map_flat  = ent_q;

  function automatic logic [MAP_W-1:0] ent_at(input logic [SEL_W-1:0] i);
    return ent_q[i*MAP_W +: MAP_W];
  endfunction

  // R2: set bit 7 advances the index after a data access
  assert_autoinc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && idx_q[AUTOINC_BIT]) |=> (idx_q == $past(idx_q) + 8'd1));

  // R2: clear bit 7 leaves the index alone
  assert_no_autoinc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !idx_q[AUTOINC_BIT] && !idx_we) |=> $stable(idx_q));

  // R3: byte write leaves the upper entry bits at ones
  assert_byte_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !data_word) |=> ((ent_at($past(sel)) | MAP_W'(8'hFF)) == {MAP_W{1'b1}}));
endmodule

// File: rtl/ccp_cfg_file.sv
module ccp_cfg_file
  import ccp_pkg::*;
#(
  parameter logic [3:0] REVISION      = 4'h8,
  parameter bit         HAS_CFG_INDEX = 1'b1,
  parameter bit         HAS_SLEEP     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_we,
  input  logic                 data_we,
  input  logic [7:0]           wdata,
  input  logic [2:0]           strap_memcfg,
  input  logic                 strap_cr1_bit,
  input  logic                 strap_big_mem,
  output logic [7:0]           idx_q,
  output logic [7:0]           rd_byte,
  output logic [NUM_CFG*8-1:0] cfg_flat
);
  localparam logic [7:0] CR5_MASK = HAS_SLEEP ? 8'hFF : 8'h0F;
  localparam logic [4:0] CR0_RST  = 5'b00100;

  logic [4:0] cr0_q, cr0_d;
  logic [7:0] cr1_q, cr1_d;
  logic [7:0] cr2_q, cr2_d;
  logic [7:0] cr3_q, cr3_d;
  logic [3:0] cr4_q, cr4_d;
  logic [7:0] cr5_q, cr5_d;
  logic [6:0] cr6_q, cr6_d;
  logic [CFG_SEL_W-1:0] rsel;
  logic [7:0] view [NUM_CFG];

  assign rsel = idx_q[CFG_SEL_W-1:0];

  generate
    if (HAS_CFG_INDEX) begin : g_idx
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          idx_q <= '0;
        else if (idx_we)
          idx_q <= wdata;
      end
    end else begin : g_no_idx
      assign idx_q = 8'h00;
    end
  endgenerate

  always_comb begin
    cr0_d = cr0_q;
    cr1_d = cr1_q;
    cr2_d = cr2_q;
    cr3_d = cr3_q;
    cr4_d = cr4_q;
    cr5_d = cr5_q;
    cr6_d = cr6_q;
    if (data_we) begin
      case (rsel)
        3'd0: cr0_d = wdata[4:0];
        3'd1: cr1_d = wdata & 8'hBF;
        3'd2: cr2_d = wdata;
        3'd3: cr3_d = wdata;
        3'd4: cr4_d = wdata[3:0];
        3'd5: cr5_d = wdata & CR5_MASK;
        3'd6: cr6_d = wdata[7:1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q <= CR0_RST;
      cr1_q <= '0;
      cr2_q <= '0;
      cr3_q <= '0;
      cr4_q <= '0;
      cr5_q <= '0;
      cr6_q <= '0;
    end else if (data_we) begin
      cr0_q <= cr0_d;
      cr1_q <= cr1_d;
      cr2_q <= cr2_d;
      cr3_q <= cr3_d;
      cr4_q <= cr4_d;
      cr5_q <= cr5_d;
      cr6_q <= cr6_d;
    end
  end

  assign view[0] = {strap_memcfg, cr0_q};
  assign view[1] = {cr1_q[7], strap_cr1_bit, cr1_q[5:0]};
  assign view[2] = cr2_q;
  assign view[3] = cr3_q;
  assign view[4] = {REVISION, cr4_q};
  assign view[5] = cr5_q;

  generate
    if (REVISION == 4'h8) begin : g_cr6
      assign view[6] = {cr6_q, strap_big_mem};
    end else begin : g_no_cr6
      assign view[6] = 8'h00;
    end
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_flat
      assign cfg_flat[g*8 +: 8] = view[g];
    end
  endgenerate

  always_comb begin
    if (int'(rsel) < NUM_CFG)
      rd_byte = view[rsel];
    else
      rd_byte = ALL_ONES[7:0];
  end

  // R5: register 0 writable bits follow the write one cycle later
  assert_cr0_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && rsel == 3'd0) |=> (cfg_flat[4:0] == $past(wdata[4:0])));

  // R6: revision nibble never moves, even right after a register 4 write
  assert_cr4_rev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && rsel == 3'd4) |=> (cfg_flat[39:36] == REVISION));
endmodule

// File: rtl/chipset_cfg_port.sv
module chipset_cfg_port
  import ccp_pkg::*;
#(
  parameter int         NUM_MAP       = 64,
  parameter int         MAP_W         = 12,
  parameter logic [3:0] REVISION      = 4'h8,
  parameter bit         HAS_CFG_INDEX = 1'b1,
  parameter bit         HAS_SLEEP     = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic                     bus_word,
  input  logic [1:0]               bus_addr,
  input  logic [15:0]              bus_wdata,
  output logic [15:0]              bus_rdata,
  input  logic [2:0]               strap_memcfg,
  input  logic                     strap_cr1_bit,
  input  logic                     strap_big_mem,
  output logic [NUM_CFG*8-1:0]     cfg_regs,
  output logic [NUM_MAP*MAP_W-1:0] map_regs,
  output logic                     cfg_changed
);
  localparam int HI_W = 16 - MAP_W;

  logic            any_wr;
  logic            map_acc, map_we, map_idx_we;
  logic            cfg_idx_we, cfg_we;
  logic [7:0]      map_idx, cfg_idx, cfg_rd;
  logic [MAP_W-1:0] entry;
  logic [15:0]     entry_word;
  logic            chg_d, chg_q;

  assign any_wr     = bus_sel && bus_wr;
  assign map_acc    = bus_sel && (bus_addr == OFS_MAP_DATA);
  assign map_we     = any_wr && (bus_addr == OFS_MAP_DATA);
  assign map_idx_we = any_wr && !bus_word && (bus_addr == OFS_MAP_IDX);
  assign cfg_idx_we = any_wr && !bus_word && (bus_addr == OFS_CFG_IDX);
  assign cfg_we     = any_wr && !bus_word && (bus_addr == OFS_CFG_DATA);

  ccp_map_file #(.NUM_MAP(NUM_MAP), .MAP_W(MAP_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_we    (map_idx_we),
    .data_acc  (map_acc),
    .data_we   (map_we),
    .data_word (bus_word),
    .wdata     (bus_wdata),
    .idx_q     (map_idx),
    .sel_entry (entry),
    .map_flat  (map_regs)
  );

  ccp_cfg_file #(.REVISION(REVISION), .HAS_CFG_INDEX(HAS_CFG_INDEX),
                 .HAS_SLEEP(HAS_SLEEP)) u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .idx_we        (cfg_idx_we),
    .data_we       (cfg_we),
    .wdata         (bus_wdata[7:0]),
    .strap_memcfg  (strap_memcfg),
    .strap_cr1_bit (strap_cr1_bit),
    .strap_big_mem (strap_big_mem),
    .idx_q         (cfg_idx),
    .rd_byte       (cfg_rd),
    .cfg_flat      (cfg_regs)
  );

  // word view of the selected entry with the read mask from register 4 bit 7
  assign entry_word = {{HI_W{1'b1}}, entry} |
                      (cfg_regs[39] ? 16'hF000 : 16'hFC00);

  always_comb begin
    bus_rdata = ALL_ONES;
    case (bus_addr)
      OFS_MAP_DATA: bus_rdata = bus_word ? entry_word : {8'hFF, entry[7:0]};
      OFS_CFG_IDX:  if (!bus_word && HAS_CFG_INDEX) bus_rdata = {8'hFF, cfg_idx};
      OFS_MAP_IDX:  if (!bus_word) bus_rdata = {8'hFF, map_idx};
      OFS_CFG_DATA: if (!bus_word) bus_rdata = {8'hFF, cfg_rd};
      default: ;
    endcase
  end

  assign chg_d = any_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chg_q <= 1'b0;
    else
      chg_q <= chg_d;
  end

  assign cfg_changed = chg_q;

  // R11: a write is followed by the pulse, anything else by no pulse
  assert_pulse_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr) |=> cfg_changed);
  assert_no_pulse_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> !cfg_changed);
endmodule

// File: tb/chipset_cfg_port_tb.sv
module chipset_cfg_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAP_W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = 3'b000;
  logic        b_wr = 1'b0, b_word = 1'b0;
  logic [1:0]  b_addr = 2'd0;
  logic [15:0] b_wdata = 16'h0;
  logic [15:0] rd_a, rd_b, rd_c;
  logic [55:0] cfg_a, cfg_b, cfg_c;
  logic [767:0] map_a, map_b, map_c;
  logic        chg_a, chg_b, chg_c;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chipset_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[0]), .bus_wr(b_wr), .bus_word(b_word),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rd_a),
    .strap_memcfg(3'b101), .strap_cr1_bit(1'b1), .strap_big_mem(1'b1),
    .cfg_regs(cfg_a), .map_regs(map_a), .cfg_changed(chg_a));

  chipset_cfg_port #(.REVISION(4'h1), .HAS_SLEEP(1'b0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[1]), .bus_wr(b_wr), .bus_word(b_word),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rd_b),
    .strap_memcfg(3'b101), .strap_cr1_bit(1'b1), .strap_big_mem(1'b1),
    .cfg_regs(cfg_b), .map_regs(map_b), .cfg_changed(chg_b));

  chipset_cfg_port #(.HAS_CFG_INDEX(1'b0)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[2]), .bus_wr(b_wr), .bus_word(b_word),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rd_c),
    .strap_memcfg(3'b101), .strap_cr1_bit(1'b1), .strap_big_mem(1'b1),
    .cfg_regs(cfg_c), .map_regs(map_c), .cfg_changed(chg_c));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input int d, input bit wr, input bit word, input logic [1:0] a,
                     input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    sel = 3'b001 << d;
    b_wr = wr; b_word = word; b_addr = a; b_wdata = wd;
    #1;
    rd = (d == 0) ? rd_a : ((d == 1) ? rd_b : rd_c);
    @(posedge clk);
    #1;
    sel = 3'b000; b_wr = 1'b0; b_word = 1'b0;
  endtask

  task automatic wrb(input int d, input logic [1:0] a, input logic [7:0] v);
    logic [15:0] r;
    acc(d, 1'b1, 1'b0, a, {8'h00, v}, r);
  endtask

  task automatic rdb(input int d, input logic [1:0] a, output logic [15:0] r);
    acc(d, 1'b0, 1'b0, a, 16'h0, r);
  endtask

  task automatic wr_cfg(input int d, input logic [7:0] i, input logic [7:0] v);
    wrb(d, 2'd1, i);
    wrb(d, 2'd3, v);
  endtask

  task automatic rd_cfg(input int d, input logic [7:0] i, output logic [15:0] r);
    wrb(d, 2'd1, i);
    rdb(d, 2'd3, r);
  endtask

  function automatic logic [11:0] ent(input logic [767:0] m, input int i);
    return m[i*MAP_W +: MAP_W];
  endfunction

  task automatic t_reset();
    logic [15:0] r;
    chk("R9 map all zero", {15'h0, map_a == '0}, 16'h1);
    chk("R9 no pulse at reset", {15'h0, chg_a}, 16'h0);
    rdb(0, 2'd2, r); chk("R9 map index", r, 16'hFF00);
    rdb(0, 2'd1, r); chk("R9 cfg index", r, 16'hFF00);
    rdb(0, 2'd3, r); chk("R9 R5 cr0 reset view", r, 16'hFFA4);
    rd_cfg(0, 8'd4, r); chk("R9 R6 cr4 reset A", r, 16'hFF80);
    rd_cfg(1, 8'd4, r); chk("R9 R6 cr4 reset B", r, 16'hFF10);
    rd_cfg(0, 8'd1, r); chk("R9 R5 cr1 reset", r, 16'hFF40);
    acc(0, 1'b0, 1'b1, 2'd0, 16'h0, r); chk("R9 R4 entry0 word A", r, 16'hF000);
    acc(1, 1'b0, 1'b1, 2'd0, 16'h0, r); chk("R9 R4 entry0 word B", r, 16'hFC00);
  endtask

  task automatic t_cfg_masks();
    logic [15:0] r;
    wr_cfg(0, 8'd0, 8'hFF); rd_cfg(0, 8'd0, r); chk("R5 cr0 ones", r, 16'hFFBF);
    wr_cfg(0, 8'd0, 8'h00); rd_cfg(0, 8'd0, r); chk("R5 cr0 zeros", r, 16'hFFA0);
    wr_cfg(0, 8'd1, 8'h00); rd_cfg(0, 8'd1, r); chk("R5 cr1 strap bit", r, 16'hFF40);
    wr_cfg(0, 8'd1, 8'hA5); rd_cfg(0, 8'd1, r); chk("R5 cr1 mixed", r, 16'hFFE5);
    wr_cfg(0, 8'd2, 8'h5A); rd_cfg(0, 8'd2, r); chk("R5 cr2", r, 16'hFF5A);
    wr_cfg(0, 8'd3, 8'hC3); rd_cfg(0, 8'd3, r); chk("R5 cr3", r, 16'hFFC3);
    chk("R5 cfg_regs cr2 out", {8'h00, cfg_a[23:16]}, 16'h005A);
    rdb(0, 2'd1, r); chk("R1 cfg index readback", r, 16'hFF03);
    wr_cfg(0, 8'd4, 8'hFF); rd_cfg(0, 8'd4, r); chk("R6 cr4 A", r, 16'hFF8F);
    wr_cfg(1, 8'd4, 8'h3C); rd_cfg(1, 8'd4, r); chk("R6 cr4 B", r, 16'hFF1C);
  endtask

  task automatic t_rev_features();
    logic [15:0] r;
    wr_cfg(0, 8'd5, 8'hA5); rd_cfg(0, 8'd5, r); chk("R7 cr5 sleep", r, 16'hFFA5);
    wr_cfg(1, 8'd5, 8'hA5); rd_cfg(1, 8'd5, r); chk("R7 cr5 no sleep", r, 16'hFF05);
    wr_cfg(0, 8'd6, 8'h00); rd_cfg(0, 8'd6, r); chk("R8 cr6 strap bit", r, 16'hFF01);
    wr_cfg(0, 8'd6, 8'hAA); rd_cfg(0, 8'd6, r); chk("R8 cr6 write", r, 16'hFFAB);
    wr_cfg(1, 8'd6, 8'hFF); rd_cfg(1, 8'd6, r); chk("R8 cr6 other rev", r, 16'hFF00);
  endtask

  task automatic t_map_write();
    logic [15:0] r;
    wrb(0, 2'd2, 8'h09);
    acc(0, 1'b1, 1'b1, 2'd0, 16'h1234, r);
    chk("R3 word write drops 15:12", {4'h0, ent(map_a, 9)}, 16'h0234);
    acc(0, 1'b0, 1'b1, 2'd0, 16'h0, r); chk("R4 word read A", r, 16'hF234);
    rdb(0, 2'd0, r); chk("R4 byte read", r, 16'hFF34);
    wrb(0, 2'd0, 8'h12);
    chk("R3 byte write forces 11:8", {4'h0, ent(map_a, 9)}, 16'h0F12);
    wrb(1, 2'd2, 8'h02);
    acc(1, 1'b1, 1'b1, 2'd0, 16'h0123, r);
    acc(1, 1'b0, 1'b1, 2'd0, 16'h0, r); chk("R4 word read B mask", r, 16'hFD23);
    wrb(0, 2'd2, 8'h45);
    acc(0, 1'b1, 1'b1, 2'd0, 16'h0ABC, r);
    chk("R1 index bits 5:0 select entry 5", {4'h0, ent(map_a, 5)}, 16'h0ABC);
    rdb(0, 2'd2, r); chk("R2 no increment bit7 clear", r, 16'hFF45);
  endtask

  task automatic t_autoinc();
    logic [15:0] r;
    wrb(0, 2'd2, 8'h85);
    wrb(0, 2'd0, 8'h77);
    acc(0, 1'b1, 1'b1, 2'd0, 16'h0321, r);
    chk("R2 R3 first entry", {4'h0, ent(map_a, 5)}, 16'h0F77);
    chk("R2 second entry", {4'h0, ent(map_a, 6)}, 16'h0321);
    rdb(0, 2'd2, r); chk("R2 index after two", r, 16'hFF87);
    rdb(0, 2'd0, r);
    rdb(0, 2'd2, r); chk("R2 read advances", r, 16'hFF88);
    wrb(0, 2'd2, 8'hBF);
    wrb(0, 2'd0, 8'h66);
    chk("R2 entry 63", {4'h0, ent(map_a, 63)}, 16'h0F66);
    rdb(0, 2'd2, r); chk("R2 BF to C0", r, 16'hFFC0);
    wrb(0, 2'd0, 8'h55);
    chk("R2 wraps to entry 0", {4'h0, ent(map_a, 0)}, 16'h0F55);
    wrb(0, 2'd2, 8'hFF);
    wrb(0, 2'd0, 8'h44);
    rdb(0, 2'd2, r); chk("R2 FF wraps to 00", r, 16'hFF00);
    wrb(0, 2'd0, 8'h33);
    rdb(0, 2'd2, r); chk("R2 stays at 00", r, 16'hFF00);
    chk("R2 entry 0 rewritten", {4'h0, ent(map_a, 0)}, 16'h0F33);
  endtask

  task automatic t_unimpl();
    logic [15:0] r;
    rd_cfg(0, 8'd7, r); chk("R10 cfg reg 7", r, 16'hFFFF);
    acc(0, 1'b0, 1'b1, 2'd2, 16'h0, r); chk("R10 word read ofs2", r, 16'hFFFF);
    acc(0, 1'b0, 1'b1, 2'd3, 16'h0, r); chk("R10 word read ofs3", r, 16'hFFFF);
    acc(0, 1'b0, 1'b1, 2'd1, 16'h0, r); chk("R10 word read ofs1", r, 16'hFFFF);
    wrb(0, 2'd1, 8'd2);
    acc(0, 1'b1, 1'b1, 2'd3, 16'h0011, r);
    rdb(0, 2'd3, r); chk("R10 word write ofs3 ignored", r, 16'hFF5A);
    acc(0, 1'b1, 1'b1, 2'd2, 16'h0022, r);
    rdb(0, 2'd2, r); chk("R10 word write ofs2 ignored", r, 16'hFF00);
    rdb(2, 2'd1, r); chk("R10 absent cfg index", r, 16'hFFFF);
    wrb(2, 2'd1, 8'h04);
    rdb(2, 2'd3, r); chk("R10 R1 absent index selects cr0", r, 16'hFFA4);
  endtask

  task automatic t_pulse();
    logic [15:0] r;
    wrb(0, 2'd2, 8'h10);
    chk("R11 pulse after write", {15'h0, chg_a}, 16'h1);
    @(posedge clk); #1;
    chk("R11 pulse one cycle", {15'h0, chg_a}, 16'h0);
    rdb(0, 2'd2, r);
    chk("R11 no pulse after read", {15'h0, chg_a}, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_cfg_masks();
    t_rev_features();
    t_map_write();
    t_autoinc();
    t_unimpl();
    t_pulse();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule